// File: doc/BRIEF.md
# Packed SIMD Integer Min/Max Unit

This block is a one-stage datapath for a vector execution pipe. Each accepted operation carries two packed operand vectors and a 32-bit instruction word. The block decodes four things from that word: lane width, signed or unsigned comparison, maximum or minimum, and vector length. For every lane, the registered result holds either the larger or the smaller of the two matching operand lanes.

Lane width, signedness, operation and vector length are all chosen per operation from the instruction word. A short 64-bit vector drives the upper half of the result to zero. A word that does not carry this operation's encoding, or that asks for the reserved lane size, raises an undefined-instruction flag, and the result register keeps its previous contents. Register-number fields inside the word are not used here, because operand fetch and writeback belong to the surrounding pipeline.

Top module: `simd_minmax_unit`

## Requirements
- R1: With instruction bit 4 equal to 0 (maximum), each result lane equals the larger of the two matching operand lanes.
- R2: With instruction bit 4 equal to 1 (minimum), each result lane equals the smaller of the two matching operand lanes.
- R3: Instruction bits 21:20 choose the lane width: 00 gives 8-bit lanes, 01 gives 16-bit lanes and 10 gives 32-bit lanes. Lane k occupies bits k*width and up.
- R4: Instruction bit 24 equal to 1 compares lanes as unsigned values. Equal to 0, it compares them as two's-complement signed values.
- R5: Instruction bit 6 equal to 1 processes all 128 bits. Equal to 0, only the low 64 bits are processed, the upper 64 result bits are zero, and the upper operand bits have no effect.
- R6: Lane size code 11 sets out_undef together with out_valid and leaves out_result at its previous value.
- R7: A word matches only if bits 31:25 = 1111001, bit 23 = 0 and bits 11:8 = 0110. Any other word is treated as in R6. Bits 22, 19:12, 7, 5 and 3:0 have no effect on the result.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. The result and out_undef belong to that operation, and out_undef is never high without out_valid.
- R9: When two matching lanes are equal, maximum and minimum return the same bit pattern, which equals that lane value.
- R10: While rst is high, out_valid, out_undef and out_result are cleared to zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 128 | First packed operand |
| in_opb | input | 128 | Second packed operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_undef | output | 1 | Undefined or reserved encoding flag |
| out_result | output | 128 | Packed result |

## Verification
Every result, out_valid and out_undef is due exactly one clock after the cycle in which in_valid was sampled high. The bench drives inputs on the falling edge, holds them through one rising edge, and compares all outputs on the next falling edge against a lane-by-lane reference function. For undefined encodings, the expected result is the bench's own record of the last defined result, so a result that is not held shows up one cycle later at the same sample point.

// File: rtl/simd_mm_pkg.sv
package simd_mm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } lane_sz_e;

  localparam int INSN_W     = 32;
  localparam int BIT_UNS    = 24;
  localparam int BIT_MIN    = 4;
  localparam int BIT_QUAD   = 6;
  localparam int SZ_LO      = 20;
  localparam int NUM_SIZES  = 3;
  localparam int BASE_LANE  = 8;

  localparam logic [6:0] TOP_PATTERN = 7'b1111001;
  localparam logic [3:0] MID_PATTERN = 4'b0110;

  typedef struct packed {
    logic     bad;
    lane_sz_e sz;
    logic     uns;
    logic     take_min;
    logic     quad;
  } mm_dec_t;

endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import simd_mm_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mm_dec_t           dec
);

  logic top_ok;
  logic mid_ok;
  logic zero_ok;
  lane_sz_e sz_field;

  always_comb begin
    top_ok   = (insn[31:25] == TOP_PATTERN);
    mid_ok   = (insn[11:8] == MID_PATTERN);
    zero_ok  = (insn[23] == 1'b0);
    sz_field = lane_sz_e'(insn[SZ_LO+1:SZ_LO]);

    dec.sz       = sz_field;
    dec.uns      = insn[BIT_UNS];
    dec.take_min = insn[BIT_MIN];
    dec.quad     = insn[BIT_QUAD];
    dec.bad      = !(top_ok && mid_ok && zero_ok) || (sz_field == SZ_RSVD);
  end

endmodule

// File: rtl/mm_lane.sv
module mm_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              uns,
  input  logic              take_min,
  output logic [LANE_W-1:0] y
);

  logic signed [LANE_W:0] a_ext;
  logic signed [LANE_W:0] b_ext;
  logic                   a_above;

  always_comb begin
    a_ext   = {(~uns) & a[LANE_W-1], a};
    b_ext   = {(~uns) & b[LANE_W-1], b};
    a_above = (a_ext > b_ext);
    y       = (a_above ^ take_min) ? a : b;
  end

endmodule

// File: rtl/mm_lane_array.sv
module mm_lane_array #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic             uns,
  input  logic             take_min,
  output logic [VEC_W-1:0] res
);

  localparam int N_LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    mm_lane #(.LANE_W(LANE_W)) u_lane (
      .a        (opa[i*LANE_W +: LANE_W]),
      .b        (opb[i*LANE_W +: LANE_W]),
      .uns      (uns),
      .take_min (take_min),
      .y        (res[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/simd_minmax_unit.sv
module simd_minmax_unit
  import simd_mm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [VEC_W-1:0]  in_opa,
  input  logic [VEC_W-1:0]  in_opb,
  output logic              out_valid,
  output logic              out_undef,
  output logic [VEC_W-1:0]  out_result
);

  localparam int HALF_W = VEC_W / 2;

  mm_dec_t dec;
  logic [NUM_SIZES-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] shaped;

  mm_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    mm_lane_array #(
      .VEC_W  (VEC_W),
      .LANE_W (BASE_LANE << g)
    ) u_arr (
      .opa      (in_opa),
      .opb      (in_opb),
      .uns      (dec.uns),
      .take_min (dec.take_min),
      .res      (cand[g])
    );
  end

  always_comb begin
    unique case (dec.sz)
      SZ_BYTE: picked = cand[0];
      SZ_HALF: picked = cand[1];
      SZ_WORD: picked = cand[2];
      default: picked = '0;
    endcase
    shaped = picked;
    if (!dec.quad) shaped[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      out_undef <= in_valid & dec.bad;
      if (in_valid && !dec.bad) out_result <= shaped;
    end
  end

endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      in_insn,
  input logic [VEC_W-1:0] in_opa,
  input logic [VEC_W-1:0] in_opb,
  input logic             out_valid,
  input logic             out_undef,
  input logic [VEC_W-1:0] out_result
);

  localparam int HALF_W = VEC_W / 2;

  logic good_word;
  assign good_word = (in_insn[31:25] == 7'b1111001) && !in_insn[23] &&
                     (in_insn[11:8] == 4'b0110) && (in_insn[21:20] != 2'b11);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_undef_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> out_valid);

  assert_undef_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !good_word) |=> (out_undef && $stable(out_result)));

  assert_short_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && good_word && !in_insn[6]) |=> (out_result[VEC_W-1:HALF_W] == '0));

  assert_lane0_from_operand_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && good_word) |=>
      ((out_result[7:0] == $past(in_opa[7:0])) || (out_result[7:0] == $past(in_opb[7:0]))));

endmodule

bind simd_minmax_unit mm_checker #(.VEC_W(VEC_W)) u_mm_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_insn    (in_insn),
  .in_opa     (in_opa),
  .in_opb     (in_opb),
  .out_valid  (out_valid),
  .out_undef  (out_undef),
  .out_result (out_result)
);

// File: tb/tb_simd_minmax_unit.sv
module tb_simd_minmax_unit;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [31:0]   in_insn;
  logic [VW-1:0] in_opa;
  logic [VW-1:0] in_opb;
  logic          out_valid;
  logic          out_undef;
  logic [VW-1:0] out_result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [VW-1:0] last_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_minmax_unit #(.VEC_W(VW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid),
    .out_undef(out_undef), .out_result(out_result)
  );

  function automatic logic [31:0] mk_insn(input bit uns, input logic [1:0] sz,
                                          input bit quad, input bit is_min);
    logic [31:0] r;
    r = $urandom;
    r[31:25] = 7'b1111001;
    r[24]    = uns;
    r[23]    = 1'b0;
    r[21:20] = sz;
    r[11:8]  = 4'b0110;
    r[6]     = quad;
    r[4]     = is_min;
    return r;
  endfunction

  function automatic logic [VW-1:0] ref_res(input logic [31:0] insn,
                                            input logic [VW-1:0] a,
                                            input logic [VW-1:0] b);
    logic [VW-1:0] res;
    int w, n;
    bit uns, is_min, pick_a;
    logic [63:0] ax, bx, mask;
    longint sa, sb;
    res = '0;
    w = 8 << insn[21:20];
    n = (insn[6] ? 128 : 64) / w;
    uns = insn[24];
    is_min = insn[4];
    mask = (64'd1 << w) - 64'd1;
    for (int k = 0; k < n; k++) begin
      ax = 64'(a >> (k*w)) & mask;
      bx = 64'(b >> (k*w)) & mask;
      sa = longint'(ax);
      sb = longint'(bx);
      if (!uns && ax[w-1]) sa = sa - (longint'(1) << w);
      if (!uns && bx[w-1]) sb = sb - (longint'(1) << w);
      pick_a = is_min ? (sa < sb) : (sa > sb);
      res = res | (VW'(pick_a ? ax : bx) << (k*w));
    end
    return res;
  endfunction

  function automatic logic [VW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [31:0] insn,
                        input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input bit expect_undef);
    logic [VW-1:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = insn;
    in_opa   = a;
    in_opb   = b;
    exp = expect_undef ? last_res : ref_res(insn, a, b);
    @(negedge clk);
    in_valid = 1'b0;
    in_insn  = $urandom;
    in_opa   = rnd128();
    in_opb   = rnd128();
    check("R8", "out_valid", VW'(out_valid), VW'(1));
    check(expect_undef ? "R6" : "R8", "out_undef", VW'(out_undef), VW'(expect_undef));
    check(tag, "result", out_result, exp);
    last_res = exp;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] w;
    logic [VW-1:0] a, b, rmax, rmin;
    void'($urandom(32'd20240607));
    rst = 1'b1; in_valid = 1'b0; in_insn = '0; in_opa = '0; in_opb = '0;
    last_res = '0;
    repeat (3) @(negedge clk);
    check("R10", "reset out_valid", VW'(out_valid), '0);
    check("R10", "reset out_undef", VW'(out_undef), '0);
    check("R10", "reset out_result", out_result, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R8", "idle out_valid", VW'(out_valid), '0);

    // Random sweep over all size, sign, operation and length combinations (R1 R2 R3 R4 R5)
    for (int q = 0; q < 2; q++)
      for (int s = 0; s < 3; s++)
        for (int u = 0; u < 2; u++)
          for (int m = 0; m < 2; m++)
            for (int r = 0; r < 12; r++)
              run_op(m ? "R2" : "R1", mk_insn(u[0], s[1:0], q[0], m[0]), rnd128(), rnd128(), 0);

    // Most negative vs most positive, per width and sign (R4 R3)
    for (int s = 0; s < 3; s++)
      for (int u = 0; u < 2; u++)
        for (int m = 0; m < 2; m++) begin
          a = {16{8'h80}}; b = {16{8'h7F}};
          if (s == 1) begin a = {8{16'h8000}}; b = {8{16'h7FFF}}; end
          if (s == 2) begin a = {4{32'h8000_0000}}; b = {4{32'h7FFF_FFFF}}; end
          run_op("R4", mk_insn(u[0], s[1:0], 1'b1, m[0]), a, b, 0);
          run_op("R4", mk_insn(u[0], s[1:0], 1'b1, m[0]), {VW{1'b1}}, '0, 0);
        end

    // Lane boundary: only one lane differs, width decides (R3)
    a = 128'h0000_0000_0000_0000_0000_0000_0000_01FF;
    b = 128'h0000_0000_0000_0000_0000_0000_0000_0200;
    run_op("R3", mk_insn(1'b1, 2'b00, 1'b1, 1'b0), a, b, 0);
    check("R3", "byte lanes low", out_result[15:0], 16'h02FF);
    run_op("R3", mk_insn(1'b1, 2'b01, 1'b1, 1'b0), a, b, 0);
    check("R3", "half lanes low", out_result[15:0], 16'h0200);

    // Short vector: upper operands ignored, upper result zero (R5)
    a = rnd128();
    run_op("R5", mk_insn(1'b0, 2'b10, 1'b0, 1'b0), {64'hFFFF_FFFF_FFFF_FFFF, a[63:0]}, {64'h7777_0000_1234_5678, a[63:0]}, 0);
    check("R5", "upper half zero", out_result[VW-1:64], '0);
    check("R5", "low half", out_result[63:0], a[63:0]);

    // Equal lanes: max and min identical (R9)
    a = rnd128();
    w = mk_insn(1'b0, 2'b01, 1'b1, 1'b0);
    run_op("R9", w, a, a, 0);
    rmax = out_result;
    w[4] = 1'b1;
    run_op("R9", w, a, a, 0);
    rmin = out_result;
    check("R9", "max equals min", rmax, rmin);
    check("R9", "equals operand", rmin, a);

    // Reserved size holds result (R6)
    run_op("R6", mk_insn(1'b0, 2'b11, 1'b1, 1'b0), rnd128(), rnd128(), 1);
    // Non-matching words (R7)
    w = mk_insn(1'b1, 2'b00, 1'b1, 1'b1); w[9] = 1'b0;
    run_op("R7", w, rnd128(), rnd128(), 1);
    w = mk_insn(1'b1, 2'b00, 1'b1, 1'b1); w[23] = 1'b1;
    run_op("R7", w, rnd128(), rnd128(), 1);
    w = mk_insn(1'b1, 2'b00, 1'b1, 1'b1); w[28] = 1'b0;
    run_op("R7", w, rnd128(), rnd128(), 1);

    // Register-number fields have no effect (R7)
    a = rnd128(); b = rnd128();
    w = mk_insn(1'b0, 2'b00, 1'b1, 1'b0);
    run_op("R7", w, a, b, 0);
    rmax = out_result;
    w[22] = ~w[22]; w[19:12] = ~w[19:12]; w[7] = ~w[7]; w[5] = ~w[5]; w[3:0] = ~w[3:0];
    run_op("R7", w, a, b, 0);
    check("R7", "register fields ignored", out_result, rmax);

    // Valid drops after a single strobe (R8)
    @(negedge clk);
    check("R8", "out_valid after idle", VW'(out_valid), '0);
    check("R8", "out_undef after idle", VW'(out_undef), '0);

    report();
  end

endmodule